// File: doc/BRIEF.md
# Combined Program Counter and Status Register

This block holds the single 32-bit register that a processor with a 26-bit address space uses for its program counter. The one word packs four fields: the condition flags, two interrupt mask bits, the word-aligned program counter and the processor mode. A write to the program counter arrives with a 32-bit value and a flag saying whether the instruction asked for status bits to be updated (the S bit). The block decides which fields the write may touch, based on the mode stored in the register. It then updates those fields and raises a one-cycle branch pulse. Without a write, an advance strobe steps the program counter by one word.

The processor mode is the state of the block's state machine. There are four states. `MODE_USR` (00) is unprivileged. `MODE_P1` (01), `MODE_P2` (10) and `MODE_SVC` (11) are privileged and behave the same for write permission. The transitions are as follows:
- **T_RESET**: reset enters `MODE_SVC`.
- **T_RELOAD**: from any privileged state, a write with S set moves to the state named by bits 1:0 of the written value. This includes dropping to `MODE_USR`.
- **T_HOLD**: `MODE_USR` has no exit except reset. Every other write or advance keeps the current state.

Top module: `pcsr_reg`

## Requirements
- R1: While reset is active and in the cycle after it, the word reads 0x0C000003: mode 11, both interrupt masks set, flags 0, program counter 0. The branch pulse is low.
- R2: The read word places the flags at bits 31:28, the interrupt masks at bits 27:26, the program counter at bits 25:2 (selected by mask 0x03FFFFFC) and the mode at bits 1:0. A written field reads back at the same position in the cycle after the write.
- R3: In a privileged mode (01, 10 or 11), a write with S set loads the whole written word, and the new mode takes effect.
- R4: In user mode (00), a write with S set updates only the program counter and bits 31:28. The masks and the mode keep their values. For example, with status 0xF4000000, writing 0x38000003 leaves status 0x34000000 and user mode.
- R5: A write with S clear updates only bits 25:2, in every mode. All status bits keep their values.
- R6: Every write raises the branch pulse for exactly the one cycle after the write's clock edge. The pulse is low in every cycle that follows a cycle without a write.
- R7: With no write and the advance strobe high, the program counter field increases by one word and wraps from 0x03FFFFFC to 0. The status bits are unchanged.
- R8: When a write and the advance strobe occur in the same cycle, the write decides the next value and the advance is ignored.
- R9: Modes 01 and 10 grant the same S-set write permission as mode 11.
- R10: With neither a write nor an advance, the whole word holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write request to the program counter this cycle |
| wr_s | input | 1 | S bit of the writing instruction |
| wr_data | input | 32 | Value written |
| adv | input | 1 | Sequential advance strobe |
| rd_word | output | 32 | Packed flags, masks, program counter and mode |
| branch_o | output | 1 | One-cycle control-transfer pulse after a write |

## Verification
The bench covers every mode, each with eight computed data patterns and both values of S. Its model alone decides which fields survive. A design that checks the mode of the written value instead of the stored mode would let user code escalate to supervisor mode. A design that treats only mode 11 as privileged would drop mask and mode updates in modes 01 and 10. The program counter is driven across its top address: an increment that carries into bit 26 would corrupt the mask field instead of wrapping to zero. A same-cycle write and advance exposes a design that gives the advance priority, because it would land one word past the branch target.

// File: rtl/pcsr_pkg.sv
package pcsr_pkg;

    localparam int FLAG_W = 4;
    localparam int IMSK_W = 2;
    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_USR = 2'b00,
        MODE_P1  = 2'b01,
        MODE_P2  = 2'b10,
        MODE_SVC = 2'b11
    } mode_e;

    typedef struct packed {
        logic ld_pc;
        logic ld_flags;
        logic ld_ctrl;
    } wr_perm_t;

endpackage

// File: rtl/pcsr_wr_perm.sv
module pcsr_wr_perm
    import pcsr_pkg::*;
(
    input  mode_e    mode,
    input  logic     wr_en,
    input  logic     wr_s,
    output wr_perm_t perm
);

    always_comb begin
        perm = '0;
        if (wr_en) begin
            perm.ld_pc = 1'b1;
            if (wr_s) begin
                unique case (mode)
                    MODE_USR: begin
                        perm.ld_flags = 1'b1;
                        perm.ld_ctrl  = 1'b0;
                    end
                    MODE_P1, MODE_P2, MODE_SVC: begin
                        perm.ld_flags = 1'b1;
                        perm.ld_ctrl  = 1'b1;
                    end
                    default: begin
                        perm.ld_flags = 1'b0;
                        perm.ld_ctrl  = 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/pcsr_pc_step.sv
module pcsr_pc_step #(
    parameter int PC_W = 24
) (
    input  logic [PC_W-1:0] pc_q,
    input  logic [PC_W-1:0] wr_pc,
    input  logic            ld_pc,
    input  logic            adv,
    output logic [PC_W-1:0] pc_d
);

    localparam logic [PC_W-1:0] ONE_WORD = PC_W'(1);

    always_comb begin
        if (ld_pc) begin
            pc_d = wr_pc;
        end else if (adv) begin
            pc_d = pc_q + ONE_WORD;
        end else begin
            pc_d = pc_q;
        end
    end

endmodule

// File: rtl/pcsr_reg.sv
module pcsr_reg
    import pcsr_pkg::*;
#(
    parameter int PC_W = 24,
    localparam int WORD_W = FLAG_W + IMSK_W + PC_W + MODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_s,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              adv,
    output logic [WORD_W-1:0] rd_word,
    output logic              branch_o
);

    localparam int PC_LSB   = MODE_W;
    localparam int IMSK_LSB = PC_LSB + PC_W;
    localparam int FLAG_LSB = IMSK_LSB + IMSK_W;

    mode_e               mode_q;
    mode_e               mode_d;
    logic [FLAG_W-1:0]   flags_q;
    logic [IMSK_W-1:0]   imsk_q;
    logic [PC_W-1:0]     pc_q;
    logic [PC_W-1:0]     pc_d;
    logic                branch_q;
    wr_perm_t            perm;

    pcsr_wr_perm i_perm (
        .mode  (mode_q),
        .wr_en (wr_en),
        .wr_s  (wr_s),
        .perm  (perm)
    );

    pcsr_pc_step #(.PC_W(PC_W)) i_step (
        .pc_q  (pc_q),
        .wr_pc (wr_data[PC_LSB +: PC_W]),
        .ld_pc (perm.ld_pc),
        .adv   (adv),
        .pc_d  (pc_d)
    );

    // Next mode: only a permitted control load can leave the current state
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_USR: mode_d = MODE_USR;
            MODE_P1, MODE_P2, MODE_SVC: begin
                if (perm.ld_ctrl) begin
                    mode_d = mode_e'(wr_data[MODE_W-1:0]);
                end
            end
            default: mode_d = MODE_SVC;
        endcase
    end

    // State register and the fields it guards
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MODE_SVC;
            imsk_q  <= '1;
            flags_q <= '0;
            pc_q    <= '0;
        end else begin
            mode_q <= mode_d;
            pc_q   <= pc_d;
            if (perm.ld_flags) begin
                flags_q <= wr_data[FLAG_LSB +: FLAG_W];
            end
            if (perm.ld_ctrl) begin
                imsk_q <= wr_data[IMSK_LSB +: IMSK_W];
            end
        end
    end

    // Output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            branch_q <= 1'b0;
        end else begin
            branch_q <= wr_en;
        end
    end

    assign rd_word  = {flags_q, imsk_q, pc_q, mode_q};
    assign branch_o = branch_q;

endmodule

// File: rtl/pcsr_reg_chk.sv
module pcsr_reg_chk
    import pcsr_pkg::*;
#(
    parameter int PC_W = 24,
    localparam int WORD_W = FLAG_W + IMSK_W + PC_W + MODE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_s,
    input logic [WORD_W-1:0] wr_data,
    input logic              adv,
    input logic [WORD_W-1:0] rd_word,
    input logic              branch_o
);

    localparam int PC_LSB = MODE_W;
    localparam int ST_LSB = PC_LSB + PC_W;
    localparam logic [WORD_W-1:0] RST_WORD =
        {{FLAG_W{1'b0}}, {IMSK_W{1'b1}}, {PC_W{1'b0}}, {MODE_W{1'b1}}};

    AST_RESET_WORD: assert property (@(posedge clk)
        !rst_n |=> (rd_word == RST_WORD) && !branch_o); // R1

    AST_PRIV_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_s && rd_word[MODE_W-1:0] != '0) |=> rd_word == $past(wr_data)); // R3

    AST_USER_CTRL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_s && rd_word[MODE_W-1:0] == '0)
        |=> $stable(rd_word[ST_LSB +: IMSK_W]) && (rd_word[MODE_W-1:0] == '0)); // R4

    AST_NO_S_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_s) |=> $stable(rd_word[WORD_W-1:ST_LSB]) && $stable(rd_word[MODE_W-1:0])); // R5

    AST_BRANCH_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> branch_o); // R6

    AST_NO_SPURIOUS_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !branch_o); // R6

    AST_ADVANCE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && adv) |=> (rd_word[PC_LSB +: PC_W] == $past(rd_word[PC_LSB +: PC_W]) + PC_W'(1))
                            && $stable(rd_word[WORD_W-1:ST_LSB])); // R7

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && adv) |=> rd_word[PC_LSB +: PC_W] == $past(wr_data[PC_LSB +: PC_W])); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !adv) |=> $stable(rd_word)); // R10

endmodule

bind pcsr_reg pcsr_reg_chk #(.PC_W(PC_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_s     (wr_s),
    .wr_data  (wr_data),
    .adv      (adv),
    .rd_word  (rd_word),
    .branch_o (branch_o)
);

// File: tb/test_pcsr_reg.sv
`timescale 1ns/1ps
module test_pcsr_reg;

    localparam logic [31:0] PC_MASK  = 32'h03FF_FFFC;
    localparam logic [31:0] RST_WORD = 32'h0C00_0003;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_s = 1'b0;
    logic [31:0] wr_data = '0;
    logic        adv = 1'b0;
    logic [31:0] rd_word;
    logic        branch_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] model;

    always #2 clk = ~clk;

    pcsr_reg i_pcsr_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_s     (wr_s),
        .wr_data  (wr_data),
        .adv      (adv),
        .rd_word  (rd_word),
        .branch_o (branch_o)
    );

    function automatic logic [31:0] next_word(logic [31:0] cur, logic [31:0] d, logic s);
        logic [31:0] r;
        r = (cur & ~PC_MASK) | (d & PC_MASK);
        if (s) begin
            if (cur[1:0] != 2'b00) r = d;
            else r = {d[31:28], r[27:0]};
        end
        return r;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; adv = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model = RST_WORD;
    endtask

    task automatic do_write(string tag, logic [31:0] d, logic s, logic with_adv);
        @(negedge clk);
        wr_en = 1'b1; wr_s = s; wr_data = d; adv = with_adv;
        @(negedge clk);
        wr_en = 1'b0; wr_s = 1'b0; adv = 1'b0;
        model = next_word(model, d, s);
        check(tag, rd_word, model);
        check("R6 pulse", {31'd0, branch_o}, 32'd1);
        @(negedge clk);
        check("R6 single", {31'd0, branch_o}, 32'd0);
        check("R10 hold", rd_word, model);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] pat;
        logic [31:0] pcv;
        model = RST_WORD;
        @(negedge clk);
        @(negedge clk);
        check("R1 during reset", rd_word, RST_WORD);
        check("R1 branch low", {31'd0, branch_o}, 32'd0);
        do_reset();
        check("R1 after reset", rd_word, RST_WORD);

        // Sweep: every mode, eight patterns, both S values
        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 8; k++) begin
                for (int s = 0; s < 2; s++) begin
                    do_reset();
                    do_write("R3 setup", (32'h5A5A_5A5C ^ (32'(k) << 28)) | 32'(m), 1'b1, 1'b0);
                    pat = (32'(k + 1) * 32'h9E37_79B9) ^ (32'(k) << 26) ^ 32'(3 - m);
                    if (s == 0)      do_write("R5 pc only", pat, 1'b0, 1'b0);
                    else if (m == 0) do_write("R4 user", pat, 1'b1, 1'b0);
                    else if (m == 3) do_write("R3 svc", pat, 1'b1, 1'b0);
                    else             do_write("R9 privileged", pat, 1'b1, 1'b0);
                    check("R2 pc field", rd_word & PC_MASK, pat & PC_MASK);
                end
            end
        end

        // Directed escalation attempt from user mode
        do_reset();
        do_write("R3 drop to user", 32'hF400_0000 | 32'h0000_1000, 1'b1, 1'b0);
        check("R2 status", rd_word & ~PC_MASK, 32'hF400_0000);
        do_write("R4 escalate", 32'h3800_0003 | 32'h0000_2000, 1'b1, 1'b0);
        check("R4 status", rd_word & ~PC_MASK, 32'h3400_0000);

        // Advance and wrap
        do_reset();
        do_write("R5 near top", 32'hFFFF_FFF8, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            adv = 1'b1;
            @(negedge clk);
            adv = 1'b0;
            pcv = ((model & PC_MASK) + 32'd4) & PC_MASK;
            model = (model & ~PC_MASK) | pcv;
            check("R7 advance", rd_word, model);
            check("R6 no pulse", {31'd0, branch_o}, 32'd0);
        end

        // Write beats advance
        do_write("R8 write wins", 32'h0012_3450, 1'b0, 1'b1);

        // Idle hold over several cycles
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R10 idle", rd_word, model);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule